// File: doc/BRIEF.md
# Multi-Kernel Workgroup Dispatch Scheduler

This block sits between a queue of launched kernels and an array of compute resources. Each kernel is launched with its kernel ID and the number of workgroups in each of three dimensions. The block keeps a small table of per-kernel state indexed by kernel ID and a pending queue of kernel IDs. It offers workgroups from the kernel at the head of that queue to the array over a valid/accept/refuse handshake. Each offered workgroup carries a linear index and x/y/z coordinates.

When the array lacks the resources for a workgroup, it refuses the offer. The refused kernel then moves to the tail of the pending queue and the next kernel gets a turn, so a kernel with smaller workgroups can still make progress. A scheduling pass stops once the number of queued kernels is no greater than the number of refusals counted in that pass. A new pass is requested by every launch and every completion.

Completion pulses from the array are tagged with a kernel ID and counted per kernel. When a kernel's completions equal its workgroup total, its ID goes into a done queue. At the end of a pass with finished kernels, the block raises one host-wakeup pulse and then reports the finished IDs one per cycle.

Top module: `wg_dispatch_sched`

## Requirements
- R1: During and right after reset, `wg_valid`, `host_wake`, `done_valid` and `busy` are all 0.
- R2: A launched kernel's first workgroup is offered two cycles after the launch cycle. While the array accepts, its workgroups follow on consecutive cycles with linear index 0, 1, 2, ...
- R3: The coordinates advance x first. x wraps to 0 after its count minus one and y steps. When y also wraps, z steps.
- R4: While `wg_valid` is high and neither `wg_accept` nor `wg_refuse` is high, the offer holds with the same kernel ID, index and coordinates. Accept wins when both are high.
- R5: On a refusal, the kernel moves to the tail of the pending queue and the next queued kernel is offered in the following cycle. The refused workgroup is later offered again with the same index.
- R6: A pass ends when the pending queue holds no more kernels than the refusals counted in that pass. After that, no workgroup is offered until the next launch or completion.
- R7: A kernel leaves the pending queue once its last workgroup is accepted and is never offered again.
- R8: A kernel counts as finished only when its completion pulses reach its workgroup total (nx*ny*nz).
- R9: If kernels finished by the end of a pass, `host_wake` pulses for exactly one cycle. `done_valid` then reports the finished IDs on the following cycles, one per cycle, in finishing order.
- R10: A completion pulse starts a new pass, so a kernel refused earlier is offered again after a completion.
- R11: `busy` is high exactly while the pending queue is non-empty or a launched kernel has not finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_valid | input | 1 | Launch a kernel this cycle |
| launch_kid | input | KW | ID of the launched kernel |
| launch_nx | input | DIMW | Workgroup count in x (at least 1) |
| launch_ny | input | DIMW | Workgroup count in y (at least 1) |
| launch_nz | input | DIMW | Workgroup count in z (at least 1) |
| wg_valid | output | 1 | A workgroup is offered |
| wg_kid | output | KW | Kernel of the offered workgroup |
| wg_gid | output | CW | Linear workgroup index |
| wg_x | output | DIMW | x coordinate |
| wg_y | output | DIMW | y coordinate |
| wg_z | output | DIMW | z coordinate |
| wg_accept | input | 1 | Array takes the offered workgroup |
| wg_refuse | input | 1 | Array lacks resources for it |
| cmp_valid | input | 1 | One workgroup completed |
| cmp_kid | input | KW | Kernel of the completed workgroup |
| done_valid | output | 1 | A finished kernel ID is reported |
| done_kid | output | KW | Finished kernel ID |
| host_wake | output | 1 | One-cycle wakeup pulse for the host |
| busy | output | 1 | Work is queued or outstanding |

## Verification
The assertions watch the handshake on every cycle. They check that a pending offer stays stable and that successive accepted workgroups of one kernel step their index by one. They check that a refusal moves the offer to another kernel or ends the pass, that the wakeup is a single pulse which alone opens a run of done reports, and that nothing is offered while the block is idle. Only the bench scenarios can show the things that span whole passes. These are the exact coordinate order in three dimensions and the fact that a refused workgroup returns with its old index after a completion. They also include a pass that stops for good when every kernel is refused, the completion threshold, and the order in which finished kernels are reported.

// File: rtl/wgd_pkg.sv
// Shared types for the workgroup dispatch scheduler.
package wgd_pkg;
    // Scheduler phases: wait for a pass request, offer workgroups,
    // wake the host, report finished kernels.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAKE  = 2'd2,
        ST_DRAIN = 2'd3
    } wgd_state_e;
endpackage

// File: rtl/wgd_idq.sv
// ID queue: circular FIFO of kernel IDs with two push lanes and one pop.
// Lane A is written before lane B in the same cycle, so a head that is
// popped and pushed on lane A rotates behind older entries but ahead
// of a simultaneous lane-B push.
// Assumes DEPTH is a power of two and the user never overfills it.
module wgd_idq #(
    parameter int DEPTH = 8,
    parameter int IW    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_a,
    input  logic [IW-1:0]                id_a,
    input  logic                         push_b,
    input  logic [IW-1:0]                id_b,
    input  logic                         pop,
    output logic [IW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [IW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CNTW-1:0] cnt;

    // Storage writes, lane A at the write pointer, lane B just after it.
    always_ff @(posedge clk) begin
        if (push_a) mem[wr_ptr] <= id_a;
        if (push_b) mem[wr_ptr + PW'(push_a)] <= id_b;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(push_a) + PW'(push_b);
            rd_ptr <= rd_ptr + PW'(pop);
            cnt    <= cnt + CNTW'(push_a) + CNTW'(push_b) - CNTW'(pop);
        end
    end

    assign head  = mem[rd_ptr];
    assign count = cnt;
endmodule

// File: rtl/wgd_ktable.sv
// Per-kernel state table indexed by kernel ID: workgroup counts, the next
// workgroup to offer (linear index and x/y/z), and the completion count.
// Assumes every count is at least 1 and that a kernel ID is not relaunched
// while it is still live.
module wgd_ktable #(
    parameter int NK   = 8,
    parameter int DIMW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_valid,
    input  logic [$clog2(NK)-1:0]    ld_kid,
    input  logic [DIMW-1:0]          ld_nx,
    input  logic [DIMW-1:0]          ld_ny,
    input  logic [DIMW-1:0]          ld_nz,
    input  logic [$clog2(NK)-1:0]    hd_kid,
    input  logic                     adv,
    input  logic                     cmp_valid,
    input  logic [$clog2(NK)-1:0]    cmp_kid,
    output logic                     hd_more,
    output logic                     hd_last,
    output logic [3*DIMW-1:0]        hd_gid,
    output logic [DIMW-1:0]          hd_x,
    output logic [DIMW-1:0]          hd_y,
    output logic [DIMW-1:0]          hd_z,
    output logic                     cmp_last,
    output logic [NK-1:0]            live
);
    localparam int KW = $clog2(NK);
    localparam int CW = 3 * DIMW;

    logic [CW-1:0]   e_gid  [NK];
    logic [CW-1:0]   e_tot  [NK];
    logic [CW-1:0]   e_ncmp [NK];
    logic [DIMW-1:0] e_x    [NK];
    logic [DIMW-1:0] e_y    [NK];
    logic [DIMW-1:0] e_z    [NK];

    for (genvar i = 0; i < NK; i++) begin : g_ent
        logic [DIMW-1:0] nx, ny, nz, x, y, z;
        logic [CW-1:0]   gid, total, ncmp;
        logic            act;
        logic            sel_ld, sel_adv, sel_cmp;

        assign sel_ld  = ld_valid  && (ld_kid  == KW'(i));
        assign sel_adv = adv       && (hd_kid  == KW'(i));
        assign sel_cmp = cmp_valid && (cmp_kid == KW'(i));

        // Load on launch, step the x-major cursor on accept, count completions.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nx <= '0; ny <= '0; nz <= '0;
                x  <= '0; y  <= '0; z  <= '0;
                gid <= '0; total <= '0; ncmp <= '0;
                act <= 1'b0;
            end else if (sel_ld) begin
                nx <= ld_nx; ny <= ld_ny; nz <= ld_nz;
                x  <= '0; y  <= '0; z  <= '0;
                gid   <= '0;
                ncmp  <= '0;
                total <= CW'(ld_nx) * CW'(ld_ny) * CW'(ld_nz);
                act   <= 1'b1;
            end else begin
                if (sel_adv) begin
                    gid <= gid + CW'(1);
                    if (x == nx - DIMW'(1)) begin
                        x <= '0;
                        if (y == ny - DIMW'(1)) begin
                            y <= '0;
                            z <= z + DIMW'(1);
                        end else begin
                            y <= y + DIMW'(1);
                        end
                    end else begin
                        x <= x + DIMW'(1);
                    end
                end
                if (sel_cmp) begin
                    ncmp <= ncmp + CW'(1);
                    if (ncmp + CW'(1) == total) act <= 1'b0;
                end
            end
        end

        assign e_gid[i]  = gid;
        assign e_tot[i]  = total;
        assign e_ncmp[i] = ncmp;
        assign e_x[i]    = x;
        assign e_y[i]    = y;
        assign e_z[i]    = z;
        assign live[i]   = act;
    end

    assign hd_gid   = e_gid[hd_kid];
    assign hd_x     = e_x[hd_kid];
    assign hd_y     = e_y[hd_kid];
    assign hd_z     = e_z[hd_kid];
    assign hd_more  = e_gid[hd_kid] != e_tot[hd_kid];
    assign hd_last  = (e_gid[hd_kid] + CW'(1)) == e_tot[hd_kid];
    assign cmp_last = cmp_valid && ((e_ncmp[cmp_kid] + CW'(1)) == e_tot[cmp_kid]);
endmodule

// File: rtl/wg_dispatch_sched.sv
// Workgroup dispatch scheduler. It walks the pending kernel queue and
// offers the head kernel's workgroups to the compute array. A refused
// kernel rotates to the tail and a per-pass fail count ends the pass. It
// counts completions per kernel, wakes the host once per pass that saw
// finished kernels, and then reports their IDs.
// Assumes NK is a power of two, launch counts are at least 1, and a
// kernel ID is reused only after it has finished.
module wg_dispatch_sched #(
    parameter int NK   = 8,
    parameter int DIMW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     launch_valid,
    input  logic [$clog2(NK)-1:0]    launch_kid,
    input  logic [DIMW-1:0]          launch_nx,
    input  logic [DIMW-1:0]          launch_ny,
    input  logic [DIMW-1:0]          launch_nz,
    output logic                     wg_valid,
    output logic [$clog2(NK)-1:0]    wg_kid,
    output logic [3*DIMW-1:0]        wg_gid,
    output logic [DIMW-1:0]          wg_x,
    output logic [DIMW-1:0]          wg_y,
    output logic [DIMW-1:0]          wg_z,
    input  logic                     wg_accept,
    input  logic                     wg_refuse,
    input  logic                     cmp_valid,
    input  logic [$clog2(NK)-1:0]    cmp_kid,
    output logic                     done_valid,
    output logic [$clog2(NK)-1:0]    done_kid,
    output logic                     host_wake,
    output logic                     busy
);
    import wgd_pkg::*;

    localparam int KW   = $clog2(NK);
    localparam int CNTW = $clog2(NK + 1);

    wgd_state_e      state;
    logic [CNTW-1:0] fail_cnt;
    logic            pass_pend;

    logic [KW-1:0]   q_head, d_head;
    logic [CNTW-1:0] q_count, d_count;
    logic            hd_more, hd_last, cmp_last;
    logic [NK-1:0]   live;

    logic in_issue, pass_over, take, refuse, stale, q_pop, d_pop;

    assign in_issue  = (state == ST_ISSUE);
    assign pass_over = (q_count <= fail_cnt);
    assign wg_valid  = in_issue && !pass_over && hd_more;
    assign take      = wg_valid && wg_accept;
    assign refuse    = wg_valid && !wg_accept && wg_refuse;
    assign stale     = in_issue && !pass_over && !hd_more;
    assign q_pop     = (take && hd_last) || refuse || stale;
    assign d_pop     = (state == ST_DRAIN) && (d_count != '0);

    assign wg_kid     = q_head;
    assign done_valid = d_pop;
    assign done_kid   = d_head;
    assign host_wake  = (state == ST_WAKE);
    assign busy       = (q_count != '0) || (|live);

    wgd_idq #(.DEPTH(NK), .IW(KW)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_a (refuse),
        .id_a   (q_head),
        .push_b (launch_valid),
        .id_b   (launch_kid),
        .pop    (q_pop),
        .head   (q_head),
        .count  (q_count)
    );

    wgd_idq #(.DEPTH(NK), .IW(KW)) u_done (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_a (cmp_last),
        .id_a   (cmp_kid),
        .push_b (1'b0),
        .id_b   ('0),
        .pop    (d_pop),
        .head   (d_head),
        .count  (d_count)
    );

    wgd_ktable #(.NK(NK), .DIMW(DIMW)) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (launch_valid),
        .ld_kid    (launch_kid),
        .ld_nx     (launch_nx),
        .ld_ny     (launch_ny),
        .ld_nz     (launch_nz),
        .hd_kid    (q_head),
        .adv       (take),
        .cmp_valid (cmp_valid),
        .cmp_kid   (cmp_kid),
        .hd_more   (hd_more),
        .hd_last   (hd_last),
        .hd_gid    (wg_gid),
        .hd_x      (wg_x),
        .hd_y      (wg_y),
        .hd_z      (wg_z),
        .cmp_last  (cmp_last),
        .live      (live)
    );

    // Pass request: set by launches and completions, consumed when a pass starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                             pass_pend <= 1'b0;
        else if (launch_valid || cmp_valid)     pass_pend <= 1'b1;
        else if (state == ST_IDLE && pass_pend) pass_pend <= 1'b0;
    end

    // Pass sequencing and per-pass refusal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            fail_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (pass_pend) begin
                    state    <= ST_ISSUE;
                    fail_cnt <= '0;
                end
                ST_ISSUE: begin
                    if (pass_over)   state    <= (d_count != '0) ? ST_WAKE : ST_IDLE;
                    else if (refuse) fail_cnt <= fail_cnt + CNTW'(1);
                end
                ST_WAKE:  state <= ST_DRAIN;
                ST_DRAIN: if (d_count == '0) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wgd_sched_chk.sv
// Cycle-level properties of the dispatch scheduler, bound to its top.
module wgd_sched_chk #(
    parameter int NK   = 8,
    parameter int DIMW = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   launch_valid,
    input logic                   wg_valid,
    input logic [$clog2(NK)-1:0]  wg_kid,
    input logic [3*DIMW-1:0]      wg_gid,
    input logic [DIMW-1:0]        wg_x,
    input logic [DIMW-1:0]        wg_y,
    input logic [DIMW-1:0]        wg_z,
    input logic                   wg_accept,
    input logic                   wg_refuse,
    input logic                   done_valid,
    input logic                   host_wake,
    input logic                   busy
);
    localparam int CW = 3 * DIMW;

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wg_valid && !wg_accept && !wg_refuse |=>
        wg_valid && $stable(wg_kid) && $stable(wg_gid) &&
        $stable(wg_x) && $stable(wg_y) && $stable(wg_z));

    p_gid_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wg_valid && wg_accept |=>
        !(wg_valid && wg_kid == $past(wg_kid)) || (wg_gid == $past(wg_gid) + CW'(1)));

    p_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wg_valid && wg_refuse && !wg_accept && !launch_valid |=>
        !wg_valid || (wg_kid != $past(wg_kid)));

    p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_wake |=> !host_wake);

    p_done_after_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(host_wake) || $past(done_valid));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wg_valid);
endmodule

bind wg_dispatch_sched wgd_sched_chk #(.NK(NK), .DIMW(DIMW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_valid (launch_valid),
    .wg_valid     (wg_valid),
    .wg_kid       (wg_kid),
    .wg_gid       (wg_gid),
    .wg_x         (wg_x),
    .wg_y         (wg_y),
    .wg_z         (wg_z),
    .wg_accept    (wg_accept),
    .wg_refuse    (wg_refuse),
    .done_valid   (done_valid),
    .host_wake    (host_wake),
    .busy         (busy)
);

// File: tb/test_wg_dispatch_sched.sv
// Directed bench: one task per scenario, each checking its own results.
module test_wg_dispatch_sched;
    localparam int NK   = 8;
    localparam int DIMW = 4;
    localparam int KW   = 3;
    localparam int CW   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic launch_valid = 1'b0;
    logic [KW-1:0] launch_kid = '0;
    logic [DIMW-1:0] launch_nx = '0, launch_ny = '0, launch_nz = '0;
    logic wg_valid;
    logic [KW-1:0] wg_kid;
    logic [CW-1:0] wg_gid;
    logic [DIMW-1:0] wg_x, wg_y, wg_z;
    logic wg_accept = 1'b0, wg_refuse = 1'b0;
    logic cmp_valid = 1'b0;
    logic [KW-1:0] cmp_kid = '0;
    logic done_valid;
    logic [KW-1:0] done_kid;
    logic host_wake, busy;

    always #5 clk = ~clk;

    wg_dispatch_sched #(.NK(NK), .DIMW(DIMW)) i_wg_dispatch_sched (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_kid(launch_kid),
        .launch_nx(launch_nx), .launch_ny(launch_ny), .launch_nz(launch_nz),
        .wg_valid(wg_valid), .wg_kid(wg_kid), .wg_gid(wg_gid),
        .wg_x(wg_x), .wg_y(wg_y), .wg_z(wg_z),
        .wg_accept(wg_accept), .wg_refuse(wg_refuse),
        .cmp_valid(cmp_valid), .cmp_kid(cmp_kid),
        .done_valid(done_valid), .done_kid(done_kid),
        .host_wake(host_wake), .busy(busy)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int il_kid[256], il_gid[256], il_x[256], il_y[256], il_z[256], il_cyc[256];
    int n_iss = 0, n_ref = 0;
    int dl_kid[64], dl_cyc[64], n_dn = 0;
    int wk_cyc[64], n_wk = 0;
    int cq[256], cq_wr = 0, cq_rd = 0;
    bit [NK-1:0] refuse_mask = '0;
    int hold_left = 0, hold_gid = 0, hold_kid = 0;
    bit hold_seen = 0;
    bit l_req = 0;
    int l_kid = 0, l_nx = 0, l_ny = 0, l_nz = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle of array model: observe at the falling edge, drive responses.
    task automatic cycle();
        launch_valid = l_req;
        launch_kid = KW'(l_kid);
        launch_nx = DIMW'(l_nx); launch_ny = DIMW'(l_ny); launch_nz = DIMW'(l_nz);
        l_req = 0;
        wg_accept = 1'b0; wg_refuse = 1'b0; cmp_valid = 1'b0; cmp_kid = '0;
        if (wg_valid) begin
            if (hold_left > 0) begin
                if (hold_seen)
                    check(int'(wg_gid) == hold_gid && int'(wg_kid) == hold_kid,
                          "R4", "held offer index", int'(wg_gid), hold_gid);
                hold_gid = int'(wg_gid); hold_kid = int'(wg_kid);
                hold_seen = 1; hold_left--;
            end else if (refuse_mask[wg_kid]) begin
                wg_refuse = 1'b1; n_ref++;
            end else begin
                wg_accept = 1'b1;
                il_kid[n_iss] = int'(wg_kid); il_gid[n_iss] = int'(wg_gid);
                il_x[n_iss] = int'(wg_x); il_y[n_iss] = int'(wg_y);
                il_z[n_iss] = int'(wg_z); il_cyc[n_iss] = cyc;
                n_iss++;
            end
        end
        if (done_valid) begin dl_kid[n_dn] = int'(done_kid); dl_cyc[n_dn] = cyc; n_dn++; end
        if (host_wake) begin wk_cyc[n_wk] = cyc; n_wk++; end
        if (cq_rd < cq_wr) begin cmp_valid = 1'b1; cmp_kid = KW'(cq[cq_rd]); cq_rd++; end
        cyc++;
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int c = 0; c < n; c++) cycle();
    endtask

    task automatic launch(input int kid, input int nx, input int ny, input int nz);
        l_req = 1; l_kid = kid; l_nx = nx; l_ny = ny; l_nz = nz;
        cycle();
    endtask

    task automatic complete(input int kid, input int n);
        for (int i = 0; i < n; i++) begin cq[cq_wr] = kid; cq_wr++; end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!wg_valid && !host_wake && !done_valid && !busy, "R1", "outputs in reset",
              int'({wg_valid, host_wake, done_valid, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wg_valid && !host_wake && !done_valid && !busy, "R1", "outputs after reset",
              int'({wg_valid, host_wake, done_valid, busy}), 0);
    endtask

    // 3x2x2 kernel fully accepted, then completed in two steps.
    task automatic t_single();
        int i0, l0, w0, d0, k;
        i0 = n_iss; l0 = cyc;
        launch(3, 3, 2, 2);
        run(20);
        check(n_iss - i0 == 12, "R7", "kernel 3 issue count", n_iss - i0, 12);
        check(il_cyc[i0] == l0 + 2, "R2", "first offer cycle", il_cyc[i0], l0 + 2);
        k = i0;
        for (int z = 0; z < 2; z++)
            for (int y = 0; y < 2; y++)
                for (int x = 0; x < 3; x++) begin
                    check(il_gid[k] == k - i0 && il_cyc[k] == il_cyc[i0] + (k - i0),
                          "R2", "index/back-to-back", il_gid[k], k - i0);
                    check(il_x[k] == x && il_y[k] == y && il_z[k] == z, "R3", "x coord",
                          il_x[k] * 100 + il_y[k] * 10 + il_z[k], x * 100 + y * 10 + z);
                    k++;
                end
        check(busy == 1'b1, "R11", "busy with outstanding work", int'(busy), 1);
        w0 = n_wk; d0 = n_dn;
        complete(3, 11);
        run(30);
        check(n_dn == d0 && n_wk == w0, "R8", "no done before total", n_dn - d0, 0);
        check(busy == 1'b1, "R11", "busy until last completion", int'(busy), 1);
        complete(3, 1);
        run(15);
        check(n_wk == w0 + 1, "R9", "one wake", n_wk - w0, 1);
        check(n_dn == d0 + 1 && dl_kid[d0] == 3, "R8", "kernel 3 done", dl_kid[d0], 3);
        check(dl_cyc[d0] == wk_cyc[w0] + 1, "R9", "done follows wake", dl_cyc[d0], wk_cyc[w0] + 1);
        check(busy == 1'b0 && !wg_valid, "R11", "idle after finish", int'(busy), 0);
    endtask

    // Offer held while the array stays silent.
    task automatic t_hold();
        int i0, d0;
        i0 = n_iss; d0 = n_dn;
        hold_left = 3; hold_seen = 0;
        launch(1, 2, 1, 1);
        run(12);
        check(hold_left == 0, "R4", "hold cycles consumed", hold_left, 0);
        check(n_iss - i0 == 2 && il_gid[i0] == 0 && il_kid[i0] == 1, "R4",
              "held offer accepted later", il_gid[i0], 0);
        check(il_gid[i0 + 1] == 1, "R2", "second index", il_gid[i0 + 1], 1);
        complete(1, 2);
        run(15);
        check(n_dn == d0 + 1 && dl_kid[d0] == 1, "R9", "kernel 1 reported", dl_kid[d0], 1);
    endtask

    // Kernel 2 refused, kernel 5 proceeds; pass stops; completion retries kernel 2.
    task automatic t_refuse();
        int i0, r0, d0;
        i0 = n_iss; d0 = n_dn;
        refuse_mask[2] = 1'b1;
        launch(2, 2, 1, 1);
        launch(5, 1, 1, 2);
        run(30);
        check(n_iss - i0 == 2 && il_kid[i0] == 5 && il_kid[i0 + 1] == 5, "R5",
              "only kernel 5 issued", n_iss - i0, 2);
        check(il_z[i0] == 0 && il_z[i0 + 1] == 1 && il_gid[i0 + 1] == 1, "R3",
              "z steps for 1x1x2", il_z[i0 + 1], 1);
        check(n_ref >= 1, "R5", "kernel 2 refused", n_ref, 1);
        r0 = n_ref;
        run(10);
        check(n_ref == r0 && !wg_valid, "R6", "pass stopped", n_ref - r0, 0);
        check(busy == 1'b1, "R11", "busy with refused kernel", int'(busy), 1);
        refuse_mask[2] = 1'b0;
        i0 = n_iss;
        complete(5, 2);
        run(30);
        check(n_iss - i0 == 2 && il_kid[i0] == 2 && il_gid[i0] == 0, "R10",
              "kernel 2 retried after completion", il_gid[i0], 0);
        check(il_gid[i0 + 1] == 1 && il_x[i0 + 1] == 1, "R5", "retry keeps index", il_gid[i0 + 1], 1);
        check(n_dn >= d0 + 1 && dl_kid[d0] == 5, "R9", "kernel 5 reported", dl_kid[d0], 5);
        complete(2, 2);
        run(20);
        check(busy == 1'b0, "R11", "idle after kernel 2", int'(busy), 0);
    endtask

    // Two kernels finish in the same window: one wake, finishing order kept.
    task automatic t_order();
        int w0, d0;
        launch(0, 1, 1, 1);
        launch(6, 1, 1, 1);
        run(10);
        w0 = n_wk; d0 = n_dn;
        complete(6, 1);
        complete(0, 1);
        run(20);
        check(n_wk == w0 + 1, "R9", "single wake for two kernels", n_wk - w0, 1);
        check(n_dn == d0 + 2 && dl_kid[d0] == 6 && dl_kid[d0 + 1] == 0, "R9",
              "finishing order", dl_kid[d0] * 10 + dl_kid[d0 + 1], 60);
        check(dl_cyc[d0 + 1] == dl_cyc[d0] + 1, "R9", "one per cycle", dl_cyc[d0 + 1], dl_cyc[d0] + 1);
        check(busy == 1'b0, "R11", "idle at end", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_hold();
        t_refuse();
        t_order();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule